// File: doc/BRIEF.md
# Shared-Port Receive/Transmit Copy Sequencer

This block runs two copy engines, one for receive and one for transmit, that take turns on a single DMA port. Each engine is started by a 64-bit descriptor that names a host address and a byte count. The receive engine moves a buffered packet out to host memory. The transmit engine pulls a packet from host memory into the transmit FIFO. The memory and both packet FIFOs sit outside the block: it sees only a "packet buffered" or "room available" flag and the buffered packet size.

Each engine steps through five named states. IDLE moves to FIFO_BLK on a start pulse. FIFO_BLK moves to BEGIN once its FIFO flag is high. BEGIN moves to COPY when the arbiter grants the port. COPY moves to DONE when its modeled-latency counter runs out. DONE always returns to IDLE after one cycle. The arbiter lets only one engine own the port at a time. It holds an engine in BEGIN while the port is busy. After a completion it favours the engine that was left waiting. The copy time is modeled as a fixed delay plus a per-64-byte-block factor. Receive uses the write pair of delay and factor; transmit uses the read pair.

Each engine has a 32-bit status word and a one-cycle completion event. Software polls the status word, and the completion event feeds interrupt logic outside the block.

Top module: `dma_pair_seq`

## Requirements
- R1: The descriptor carries the host address in bits [ADDR_W-1:0] (default [39:0]) and the byte count in bits [63:48]. The issued `dma_addr` equals the address field of the issuing engine's descriptor.
- R2: The receive copy length issued on `dma_len` is the smaller of the descriptor byte count and the `rx_pkt_bytes` value captured when leaving FIFO_BLK. The transmit copy length is the descriptor byte count.
- R3: An engine in FIFO_BLK issues no request until its FIFO flag is high: `rx_pkt_ready` for receive, `tx_room_ready` for transmit.
- R4: An engine in BEGIN stays there while `dma_port_busy` is high or the other engine is in COPY. Otherwise it raises `dma_issue` in that cycle and enters COPY on the next edge. `dma_to_host`=1 marks a receive request. No request is issued while a copy is in flight.
- R5: If both engines wait in BEGIN and no preference is pending, receive is granted. When a copy completes while the other engine waits in BEGIN, that waiting engine becomes preferred until it is granted.
- R6: The completion event rises L+1 cycles after the `dma_issue` cycle. L = max(1, D + ceil(len/64)*F). Receive uses D=WR_DELAY and F=WR_FACTOR; transmit uses D=RD_DELAY and F=RD_FACTOR.
- R7: An accepted start sets the engine's status word to busy only, which is bit 30 (0x4000_0000). Receive completion also sets bit 31 and keeps bit 30 (0xC000_0000). Transmit completion writes bit 31 OR the copy length in the low bits, with bit 30 clear.
- R8: `rx_dma_evt` and `tx_dma_evt` are single-cycle pulses. The engine is back in IDLE on the next cycle and accepts a new start there.
- R9: A start pulse given while the engine is not in IDLE is ignored. The descriptor, the timing and the status word of the running copy are unchanged, and no extra request follows.
- R10: During and right after reset, both status words are zero, no event is raised and no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_start | input | 1 | Start pulse for the receive engine |
| rx_desc | input | DESC_W | Receive descriptor, taken on an accepted start |
| rx_pkt_ready | input | 1 | A packet is buffered in the receive FIFO |
| rx_pkt_bytes | input | LEN_W | Size of the buffered receive packet |
| tx_start | input | 1 | Start pulse for the transmit engine |
| tx_desc | input | DESC_W | Transmit descriptor, taken on an accepted start |
| tx_room_ready | input | 1 | The transmit FIFO can take a packet |
| dma_port_busy | input | 1 | The shared port is in use outside this block |
| dma_issue | output | 1 | A request is issued on the shared port this cycle |
| dma_to_host | output | 1 | 1: receive write to host, 0: transmit read from host |
| dma_addr | output | ADDR_W | Host address of the issued request |
| dma_len | output | LEN_W | Byte count of the issued request |
| rx_done_word | output | 32 | Receive status word |
| tx_done_word | output | 32 | Transmit status word |
| rx_dma_evt | output | 1 | Receive copy completion event |
| tx_dma_evt | output | 1 | Transmit copy completion event |

## Verification
Two things can fall in the same cycle. One engine can complete its copy while the other is parked in BEGIN, and both engines can compete for the port in the same BEGIN cycle. The bench sets this up by holding `dma_port_busy` high across a receive completion and then restarting receive, so that both engines are waiting when the port is released. The first grant must then go to transmit. With no completion in between, the same setup must grant receive. Random traffic adds more overlaps and random port-busy stretches. For every request, the bench checks the direction, address, length and completion delay against values it computes itself.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIFO_BLK,
        ST_BEGIN,
        ST_COPY,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        PREF_NONE,
        PREF_RX,
        PREF_TX
    } pref_t;

    localparam int STAT_W        = 32;
    localparam int STAT_DONE_BIT = 31;
    localparam int STAT_BUSY_BIT = 30;

endpackage

// File: rtl/dseq_latency.sv
// Modeled copy time: fixed delay plus a factor per started block.
module dseq_latency #(
    parameter int LEN_W     = 16,
    parameter int CNT_W     = 24,
    parameter int DELAY     = 3,
    parameter int FACTOR    = 2,
    parameter int BLK_BYTES = 64
) (
    input  logic [LEN_W-1:0] len_i,
    output logic [CNT_W-1:0] cycles_o
);
    localparam int BLK_SH = $clog2(BLK_BYTES);
    localparam int SUM_W  = LEN_W + 1;

    logic [SUM_W-1:0] rounded;
    logic [CNT_W-1:0] blocks;
    logic [CNT_W-1:0] raw;

    always_comb begin
        rounded  = {1'b0, len_i} + SUM_W'(BLK_BYTES - 1);
        blocks   = CNT_W'(rounded >> BLK_SH);
        raw      = CNT_W'(DELAY) + blocks * CNT_W'(FACTOR);
        cycles_o = (raw == '0) ? CNT_W'(1) : raw;
    end
endmodule

// File: rtl/dseq_engine.sv
// One copy engine: IDLE -> FIFO_BLK -> BEGIN -> COPY -> DONE -> IDLE.
module dseq_engine
    import dseq_pkg::*;
#(
    parameter bit IS_RX     = 1'b1,
    parameter int DESC_W    = 64,
    parameter int ADDR_W    = 40,
    parameter int LEN_W     = 16,
    parameter int CNT_W     = 24,
    parameter int DELAY     = 3,
    parameter int FACTOR    = 2,
    parameter int BLK_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DESC_W-1:0] desc_i,
    input  logic              ready_i,
    input  logic [LEN_W-1:0]  pkt_len_i,
    input  logic              grant_i,
    output seq_state_t        state_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [STAT_W-1:0] status_o,
    output logic              evt_o,
    output logic              end_o,
    output logic              wait_o
);
    seq_state_t        state_q, state_d;
    logic [DESC_W-1:0] desc_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  lat;
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] busy_word;
    logic [STAT_W-1:0] done_word;
    logic [LEN_W-1:0]  desc_len;
    logic [LEN_W-1:0]  copy_len;

    assign desc_len = desc_q[DESC_W-1 -: LEN_W];
    assign addr_o   = desc_q[ADDR_W-1:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i)              state_d = ST_FIFO_BLK;
            ST_FIFO_BLK: if (ready_i)              state_d = ST_BEGIN;
            ST_BEGIN:    if (grant_i)              state_d = ST_COPY;
            ST_COPY:     if (cnt_q == CNT_W'(1))   state_d = ST_DONE;
            ST_DONE:                               state_d = ST_IDLE;
            default:                               state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        state_o = state_q;
        evt_o   = (state_q == ST_DONE);
        end_o   = (state_q == ST_COPY) && (cnt_q == CNT_W'(1));
        wait_o  = (state_q == ST_BEGIN);
    end

    // Length rule and completion word depend on the direction
    generate
        if (IS_RX) begin : g_rx
            logic [LEN_W-1:0] plen_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                  plen_q <= '0;
                else if (state_q == ST_FIFO_BLK && ready_i)  plen_q <= pkt_len_i;
            end
            assign copy_len = (desc_len < plen_q) ? desc_len : plen_q;
            always_comb begin
                done_word                = status_q;
                done_word[STAT_DONE_BIT] = 1'b1;
            end
        end else begin : g_tx
            logic unused_pkt_len;
            assign unused_pkt_len = ^pkt_len_i;
            assign copy_len = desc_len;
            always_comb begin
                done_word                = '0;
                done_word[LEN_W-1:0]     = copy_len;
                done_word[STAT_DONE_BIT] = 1'b1;
            end
        end
    endgenerate

    always_comb begin
        busy_word                = '0;
        busy_word[STAT_BUSY_BIT] = 1'b1;
    end

    dseq_latency #(
        .LEN_W     (LEN_W),
        .CNT_W     (CNT_W),
        .DELAY     (DELAY),
        .FACTOR    (FACTOR),
        .BLK_BYTES (BLK_BYTES)
    ) u_lat (
        .len_i    (copy_len),
        .cycles_o (lat)
    );

    // Descriptor, latency counter and status word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q   <= '0;
            cnt_q    <= '0;
            status_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                desc_q   <= desc_i;
                status_q <= busy_word;
            end
            if (state_q == ST_BEGIN && grant_i) cnt_q <= lat;
            else if (state_q == ST_COPY)        cnt_q <= cnt_q - CNT_W'(1);
            if (end_o) status_q <= done_word;
        end
    end

    assign len_o    = copy_len;
    assign status_o = status_q;
endmodule

// File: rtl/dseq_arbiter.sv
// Shared-port grant with completion-driven preference.
module dseq_arbiter
    import dseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_busy_i,
    input  seq_state_t rx_state_i,
    input  seq_state_t tx_state_i,
    input  logic       rx_end_i,
    input  logic       tx_end_i,
    output logic       grant_rx_o,
    output logic       grant_tx_o
);
    pref_t pref_q;
    logic  port_busy;
    logic  rx_wait;
    logic  tx_wait;

    always_comb begin
        port_busy  = ext_busy_i || (rx_state_i == ST_COPY) || (tx_state_i == ST_COPY);
        rx_wait    = (rx_state_i == ST_BEGIN);
        tx_wait    = (tx_state_i == ST_BEGIN);
        grant_rx_o = rx_wait && !port_busy && !(tx_wait && pref_q == PREF_TX);
        grant_tx_o = tx_wait && !port_busy && !grant_rx_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pref_q <= PREF_NONE;
        end else if (rx_end_i) begin
            pref_q <= tx_wait ? PREF_TX : PREF_NONE;
        end else if (tx_end_i) begin
            pref_q <= rx_wait ? PREF_RX : PREF_NONE;
        end else if ((grant_rx_o && pref_q == PREF_RX) ||
                     (grant_tx_o && pref_q == PREF_TX)) begin
            pref_q <= PREF_NONE;
        end
    end
endmodule

// File: rtl/dma_pair_seq.sv
module dma_pair_seq
    import dseq_pkg::*;
#(
    parameter int DESC_W    = 64,
    parameter int ADDR_W    = 40,
    parameter int LEN_W     = 16,
    parameter int CNT_W     = 24,
    parameter int WR_DELAY  = 3,
    parameter int WR_FACTOR = 2,
    parameter int RD_DELAY  = 5,
    parameter int RD_FACTOR = 1,
    parameter int BLK_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic [DESC_W-1:0] rx_desc,
    input  logic              rx_pkt_ready,
    input  logic [LEN_W-1:0]  rx_pkt_bytes,
    input  logic              tx_start,
    input  logic [DESC_W-1:0] tx_desc,
    input  logic              tx_room_ready,
    input  logic              dma_port_busy,
    output logic              dma_issue,
    output logic              dma_to_host,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [LEN_W-1:0]  dma_len,
    output logic [STAT_W-1:0] rx_done_word,
    output logic [STAT_W-1:0] tx_done_word,
    output logic              rx_dma_evt,
    output logic              tx_dma_evt
);
    seq_state_t        rx_state, tx_state;
    logic              grant_rx, grant_tx;
    logic              rx_end, tx_end;
    logic              rx_wait, tx_wait;
    logic [ADDR_W-1:0] rx_addr, tx_addr;
    logic [LEN_W-1:0]  rx_len, tx_len;

    dseq_engine #(
        .IS_RX (1'b1), .DESC_W (DESC_W), .ADDR_W (ADDR_W), .LEN_W (LEN_W),
        .CNT_W (CNT_W), .DELAY (WR_DELAY), .FACTOR (WR_FACTOR), .BLK_BYTES (BLK_BYTES)
    ) u_rx (
        .clk (clk), .rst_n (rst_n), .start_i (rx_start), .desc_i (rx_desc),
        .ready_i (rx_pkt_ready), .pkt_len_i (rx_pkt_bytes), .grant_i (grant_rx),
        .state_o (rx_state), .addr_o (rx_addr), .len_o (rx_len),
        .status_o (rx_done_word), .evt_o (rx_dma_evt), .end_o (rx_end), .wait_o (rx_wait)
    );

    dseq_engine #(
        .IS_RX (1'b0), .DESC_W (DESC_W), .ADDR_W (ADDR_W), .LEN_W (LEN_W),
        .CNT_W (CNT_W), .DELAY (RD_DELAY), .FACTOR (RD_FACTOR), .BLK_BYTES (BLK_BYTES)
    ) u_tx (
        .clk (clk), .rst_n (rst_n), .start_i (tx_start), .desc_i (tx_desc),
        .ready_i (tx_room_ready), .pkt_len_i ('0), .grant_i (grant_tx),
        .state_o (tx_state), .addr_o (tx_addr), .len_o (tx_len),
        .status_o (tx_done_word), .evt_o (tx_dma_evt), .end_o (tx_end), .wait_o (tx_wait)
    );

    dseq_arbiter u_arb (
        .clk (clk), .rst_n (rst_n), .ext_busy_i (dma_port_busy),
        .rx_state_i (rx_state), .tx_state_i (tx_state),
        .rx_end_i (rx_end), .tx_end_i (tx_end),
        .grant_rx_o (grant_rx), .grant_tx_o (grant_tx)
    );

    // Shared port request
    always_comb begin
        dma_issue   = grant_rx || grant_tx;
        dma_to_host = grant_rx;
        dma_addr    = grant_tx ? tx_addr : rx_addr;
        dma_len     = grant_tx ? tx_len  : rx_len;
    end

    logic unused_wait;
    assign unused_wait = rx_wait ^ tx_wait;
endmodule

// File: rtl/dseq_checker.sv
module dseq_checker
    import dseq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              dma_port_busy,
    input logic              dma_issue,
    input logic              dma_to_host,
    input logic              rx_evt,
    input logic              tx_evt,
    input logic [STAT_W-1:0] rx_word,
    input logic [STAT_W-1:0] tx_word,
    input seq_state_t        rx_st,
    input seq_state_t        tx_st
);
    a_r4_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dma_port_busy |-> !dma_issue);

    a_r4_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_st == ST_COPY || tx_st == ST_COPY) |-> !dma_issue);

    a_r4_issue_enters_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_issue && dma_to_host) |=> (rx_st == ST_COPY));

    a_r6_rx_evt_after_copy: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |-> ($past(rx_st) == ST_COPY));

    a_r7_tx_word: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt |-> (tx_word[STAT_DONE_BIT] && !tx_word[STAT_BUSY_BIT]));

    a_r7_rx_word: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |-> (rx_word[STAT_DONE_BIT] && rx_word[STAT_BUSY_BIT]));

    a_r8_rx_evt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |=> (!rx_evt && rx_st == ST_IDLE));

    a_r8_tx_evt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt |=> (!tx_evt && tx_st == ST_IDLE));
endmodule

bind dma_pair_seq dseq_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dma_port_busy (dma_port_busy),
    .dma_issue     (dma_issue),
    .dma_to_host   (dma_to_host),
    .rx_evt        (rx_dma_evt),
    .tx_evt        (tx_dma_evt),
    .rx_word       (rx_done_word),
    .tx_word       (tx_done_word),
    .rx_st         (rx_state),
    .tx_st         (tx_state)
);

// File: tb/dma_pair_seq_tb_top.sv
`timescale 1ns/1ps
module dma_pair_seq_tb_top;
    localparam int AW = 40, LW = 16, DW = 64;
    localparam int WRD = 3, WRF = 2, RDD = 5, RDF = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          rx_start = 0, tx_start = 0;
    logic [DW-1:0] rx_desc = '0, tx_desc = '0;
    logic          rx_pkt_ready = 0, tx_room_ready = 0, dma_port_busy = 0;
    logic [LW-1:0] rx_pkt_bytes = '0;
    logic          dma_issue, dma_to_host, rx_dma_evt, tx_dma_evt;
    logic [AW-1:0] dma_addr;
    logic [LW-1:0] dma_len;
    logic [31:0]   rx_done_word, tx_done_word;

    dma_pair_seq #(
        .DESC_W (DW), .ADDR_W (AW), .LEN_W (LW),
        .WR_DELAY (WRD), .WR_FACTOR (WRF), .RD_DELAY (RDD), .RD_FACTOR (RDF)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .rx_start (rx_start), .rx_desc (rx_desc),
        .rx_pkt_ready (rx_pkt_ready), .rx_pkt_bytes (rx_pkt_bytes),
        .tx_start (tx_start), .tx_desc (tx_desc), .tx_room_ready (tx_room_ready),
        .dma_port_busy (dma_port_busy), .dma_issue (dma_issue), .dma_to_host (dma_to_host),
        .dma_addr (dma_addr), .dma_len (dma_len), .rx_done_word (rx_done_word),
        .tx_done_word (tx_done_word), .rx_dma_evt (rx_dma_evt), .tx_dma_evt (tx_dma_evt)
    );

    int checks = 0, errors = 0;

    function automatic int f_lat(int len, int d, int f);
        int r;
        r = d + ((len + 63) / 64) * f;
        if (r < 1) r = 1;
        return r;
    endfunction

    function automatic logic [DW-1:0] f_desc(logic [AW-1:0] a, logic [LW-1:0] l);
        return {l, 8'h00, a};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: sampled on the falling edge
    int cyc = 0;
    int rx_iss_cyc = 0, tx_iss_cyc = 0, rx_latv = 0, tx_latv = 0;
    bit rx_fly = 0, tx_fly = 0, last_to_host = 0, rx_evt_prev = 0, tx_evt_prev = 0;
    int rx_iss_cnt = 0, tx_iss_cnt = 0, rx_evt_cnt = 0, tx_evt_cnt = 0;
    logic [AW-1:0] rx_exp_addr = '0, tx_exp_addr = '0;
    int rx_exp_len = 0, tx_exp_len = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (rx_dma_evt) begin
                if (!rx_evt_prev) begin
                    chk(cyc - rx_iss_cyc == rx_latv + 1, "R6 rx completion delay", cyc - rx_iss_cyc, rx_latv + 1);
                    chk(rx_done_word == 32'hC000_0000, "R7 rx completion word", rx_done_word, 32'hC000_0000);
                    rx_evt_cnt++;
                    rx_fly = 0;
                end else chk(0, "R8 rx event wider than one cycle", 1, 0);
            end
            if (tx_dma_evt) begin
                if (!tx_evt_prev) begin
                    chk(cyc - tx_iss_cyc == tx_latv + 1, "R6 tx completion delay", cyc - tx_iss_cyc, tx_latv + 1);
                    chk(tx_done_word == (32'h8000_0000 | 32'(tx_exp_len)), "R7 tx completion word",
                        tx_done_word, 32'h8000_0000 | 32'(tx_exp_len));
                    tx_evt_cnt++;
                    tx_fly = 0;
                end else chk(0, "R8 tx event wider than one cycle", 1, 0);
            end
            rx_evt_prev = rx_dma_evt;
            tx_evt_prev = tx_dma_evt;
            if (dma_issue) begin
                chk(!dma_port_busy, "R4 request while port busy", dma_port_busy, 0);
                chk(!rx_fly && !tx_fly, "R4 request while copy in flight", {rx_fly, tx_fly}, 0);
                last_to_host = dma_to_host;
                if (dma_to_host) begin
                    chk(dma_addr == rx_exp_addr, "R1 rx address", dma_addr, rx_exp_addr);
                    chk(dma_len == LW'(rx_exp_len), "R2 rx copy length", dma_len, rx_exp_len);
                    rx_iss_cyc = cyc; rx_latv = f_lat(rx_exp_len, WRD, WRF);
                    rx_fly = 1; rx_iss_cnt++;
                end else begin
                    chk(dma_addr == tx_exp_addr, "R1 tx address", dma_addr, tx_exp_addr);
                    chk(dma_len == LW'(tx_exp_len), "R2 tx copy length", dma_len, tx_exp_len);
                    tx_iss_cyc = cyc; tx_latv = f_lat(tx_exp_len, RDD, RDF);
                    tx_fly = 1; tx_iss_cnt++;
                end
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic rx_arm(logic [AW-1:0] a, int dl, int pl, bit rdy);
        rx_exp_addr = a; rx_exp_len = (dl < pl) ? dl : pl;
        rx_desc = f_desc(a, LW'(dl)); rx_pkt_bytes = LW'(pl);
        rx_pkt_ready = rdy; rx_start = 1;
    endtask

    task automatic tx_arm(logic [AW-1:0] a, int dl, bit rdy);
        tx_exp_addr = a; tx_exp_len = dl;
        tx_desc = f_desc(a, LW'(dl)); tx_room_ready = rdy; tx_start = 1;
    endtask

    task automatic rx_fire();
        step(); rx_start = 0;
        chk(rx_done_word == 32'h4000_0000, "R7 rx busy word after start", rx_done_word, 32'h4000_0000);
    endtask

    task automatic tx_fire();
        step(); tx_start = 0;
        chk(tx_done_word == 32'h4000_0000, "R7 tx busy word after start", tx_done_word, 32'h4000_0000);
    endtask

    task automatic rx_wait(int target);
        while (rx_evt_cnt < target) step();
    endtask

    task automatic tx_wait(int target);
        while (tx_evt_cnt < target) step();
    endtask

    // Watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", wd);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    bit rand_done = 0;

    initial begin
        int n0, m0, re, te;
        void'($urandom(32'd5171));
        repeat (3) step();
        // R10 reset state
        chk(rx_done_word == 0 && tx_done_word == 0, "R10 status words in reset", {rx_done_word, tx_done_word}, 0);
        chk(!dma_issue && !rx_dma_evt && !tx_dma_evt, "R10 no request or event in reset",
            {dma_issue, rx_dma_evt, tx_dma_evt}, 0);
        rst_n = 1;
        repeat (2) step();
        chk(!dma_issue && rx_done_word == 0, "R10 quiet after reset", {dma_issue, rx_done_word}, 0);

        // R2 packet shorter than descriptor, then descriptor shorter
        re = rx_evt_cnt;
        rx_arm(40'h12_3456_7800, 200, 100, 1); rx_fire(); rx_wait(re + 1); step();
        rx_arm(40'h00_0000_1040, 64, 500, 1); rx_fire(); rx_wait(re + 2); step();
        rx_arm(40'hAB_CDEF_0000, 0, 10, 1); rx_fire(); rx_wait(re + 3); step();
        // R6 block boundaries on transmit
        te = tx_evt_cnt;
        tx_arm(40'h55_0000_0100, 65, 1); tx_fire(); tx_wait(te + 1); step();
        tx_arm(40'h55_0000_0200, 0, 1); tx_fire(); tx_wait(te + 2); step();
        tx_arm(40'h55_0000_0300, 128, 1); tx_fire(); tx_wait(te + 3); step();

        // R3 FIFO-block holds requests
        n0 = rx_iss_cnt; m0 = tx_iss_cnt;
        rx_arm(40'h01_0000_0000, 90, 90, 0); tx_arm(40'h02_0000_0000, 70, 0);
        step(); rx_start = 0; tx_start = 0;
        repeat (6) step();
        chk(rx_iss_cnt == n0 && tx_iss_cnt == m0, "R3 no request while FIFO flags low",
            {rx_iss_cnt, tx_iss_cnt}, {n0, m0});
        re = rx_evt_cnt; te = tx_evt_cnt;
        rx_pkt_ready = 1; tx_room_ready = 1;
        rx_wait(re + 1); tx_wait(te + 1); step();

        // R4 external busy holds BEGIN
        dma_port_busy = 1; m0 = tx_iss_cnt; te = tx_evt_cnt;
        tx_arm(40'h03_0000_0040, 33, 1); tx_fire();
        repeat (8) step();
        chk(tx_iss_cnt == m0, "R4 tx held while port busy", tx_iss_cnt, m0);
        dma_port_busy = 0;
        tx_wait(te + 1); step();

        // R5 plain tie: receive first
        dma_port_busy = 1; n0 = rx_iss_cnt; m0 = tx_iss_cnt; re = rx_evt_cnt; te = tx_evt_cnt;
        rx_arm(40'h04_0000_0000, 128, 128, 1); tx_arm(40'h05_0000_0000, 100, 1);
        step(); rx_start = 0; tx_start = 0;
        repeat (4) step();
        dma_port_busy = 0;
        @(negedge clk); #1;
        chk(rx_iss_cnt == n0 + 1 && tx_iss_cnt == m0 && last_to_host == 1, "R5 receive wins plain tie",
            {rx_iss_cnt, tx_iss_cnt}, {n0 + 1, m0});
        step(); dma_port_busy = 1;
        rx_wait(re + 1); step();
        // R5 transmit preferred after the receive completion
        rx_arm(40'h06_0000_0000, 50, 60, 1); rx_fire();
        repeat (3) step();
        chk(rx_iss_cnt == n0 + 1 && tx_iss_cnt == m0, "R4 both held in begin-copy",
            {rx_iss_cnt, tx_iss_cnt}, {n0 + 1, m0});
        dma_port_busy = 0;
        @(negedge clk); #1;
        chk(tx_iss_cnt == m0 + 1 && last_to_host == 0, "R5 waiting transmit preferred after completion",
            {tx_iss_cnt, 31'(last_to_host)}, {m0 + 1, 0});
        tx_wait(te + 1); rx_wait(re + 2); step();

        // R9 start ignored while busy
        re = rx_evt_cnt;
        rx_arm(40'h07_0000_0000, 300, 300, 1); rx_fire();
        repeat (3) step();
        rx_desc = f_desc(40'h7F_FFFF_FFFF, 16'd5); rx_start = 1;
        step(); rx_start = 0;
        rx_wait(re + 1);
        n0 = rx_iss_cnt;
        repeat (10) step();
        chk(rx_iss_cnt == n0, "R9 ignored start issues nothing", rx_iss_cnt, n0);
        chk(rx_done_word == 32'hC000_0000, "R9 status kept after ignored start", rx_done_word, 32'hC000_0000);

        // R8 restart on the cycle after the event
        re = rx_evt_cnt;
        rx_arm(40'h08_0000_0000, 10, 10, 1); rx_fire(); rx_wait(re + 1);
        rx_arm(40'h08_0000_1000, 20, 20, 1); rx_fire(); rx_wait(re + 2);
        chk(rx_evt_cnt == re + 2, "R8 back-to-back restart accepted", rx_evt_cnt, re + 2);
        step();

        // Random overlap of both engines and port-busy stretches (R2 R4 R5 R6)
        fork
            begin
                fork
                    begin
                        for (int i = 0; i < 30; i++) begin
                            int tgt;
                            bit rdy;
                            tgt = rx_evt_cnt + 1;
                            repeat ($urandom % 4) step();
                            rdy = ($urandom % 2) == 1;
                            rx_arm(AW'({$urandom, $urandom}), int'($urandom % 400), int'(1 + $urandom % 400), rdy);
                            rx_fire();
                            if (!rdy) begin
                                repeat ($urandom % 4) step();
                                rx_pkt_ready = 1;
                            end
                            rx_wait(tgt);
                        end
                    end
                    begin
                        for (int j = 0; j < 30; j++) begin
                            int tgt;
                            bit rdy;
                            tgt = tx_evt_cnt + 1;
                            repeat ($urandom % 4) step();
                            rdy = ($urandom % 2) == 1;
                            tx_arm(AW'({$urandom, $urandom}), int'($urandom % 400), rdy);
                            tx_fire();
                            if (!rdy) begin
                                repeat ($urandom % 4) step();
                                tx_room_ready = 1;
                            end
                            tx_wait(tgt);
                        end
                    end
                join
                rand_done = 1;
            end
            begin
                while (!rand_done) begin
                    dma_port_busy = ($urandom % 5) == 0;
                    step();
                end
                dma_port_busy = 0;
            end
        join
        repeat (4) step();
        chk(!dma_issue && !rx_fly && !tx_fly, "R4 port quiet at end", {dma_issue, rx_fly, tx_fly}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule